// File: doc/BRIEF.md
# UART Receive/Transmit FIFO and Interrupt Controller

This block sits between the bit-level serial engines of a 16550-class serial port and the register bus. Received characters arrive from the deserializer one byte at a time, together with the sampled stop bit and parity bit. The block checks parity and framing as each byte is stored. Each stored entry carries its error flags, and software reads the entries back as 11-bit words. Bytes that software writes are queued for the serializer, which pops them one at a time.

Three level-sensitive interrupt lines are produced. The RX line rises when the receive queue is half full, when a character has waited three character times without further traffic, or at once when a byte is lost to overrun. The TX line rises when the transmit queue has drained to half empty. The modem line rises, if enabled, when any modem status input changes. A control bit collapses both queues to a single entry, which gives classic double-buffered operation.

Top module: `uart_fifo_irq`

## Requirements
- R1: A read of address 0 returns the oldest receive entry in the format {overrun[10], parity_err[9], framing_err[8], data[7:0]} and removes it. Entries come out in arrival order. A read of an empty queue returns 0 in bits 9:0.
- R2: Control bit 1 enables the parity check and control bit 2 selects odd parity (0 selects even). parity_err is set when checking is on and the received parity bit differs from the XOR of the data bits XORed with the odd bit. framing_err is set when the stop bit is 0.
- R3: In multi-entry mode with the default depth of 16, irq_rx_o is high whenever 8 or more entries are held, and low at 7 or fewer when no timeout or overrun is pending.
- R4: With at least one entry held, irq_rx_o rises on the 480th baud tick (3 characters × 10 bits × 16 ticks) after the last push or pop. A push clears it. It is also cleared when the queue empties. A pop restarts the tick count but leaves a raised timeout standing.
- R5: A push to a full receive queue with no pop in the same cycle drops the byte and raises irq_rx_o on the next cycle. The next data read reports bit 10 set, and that read clears it.
- R6: irq_tx_o is high whenever the transmit queue holds 8 or fewer entries in multi-entry mode, or 0 entries in single mode.
- R7: Control bit 0 selects single-entry mode, in which each queue holds one byte and irq_rx_o rises at one entry. Any write that changes this bit empties both queues and clears a pending overrun.
- R8: Any change on modem_i latches a change flag. irq_modem_o is the flag gated by control bit 3. A read of address 2 returns {flag[4], modem_i[3:0]} and clears the flag, except that a change in the same cycle wins.
- R9: modem_i has no effect on tx_valid_o or tx_data_o. Transmit continues regardless of clear-to-send.
- R10: A write to address 0 queues a byte for transmit. A write to a full transmit queue with no pop in the same cycle is ignored. tx_data_o presents the oldest byte while tx_valid_o is high, and tx_pop_i removes it.
- R11: After reset the queues are empty, multi-entry mode is selected with parity off and the modem interrupt masked, irq_rx_o and irq_modem_o are low, and irq_tx_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One pulse per oversampling tick (16 per bit) |
| rx_push_i | input | 1 | Deserializer delivers a character |
| rx_data_i | input | 8 | Received data byte |
| rx_parity_bit_i | input | 1 | Received parity bit |
| rx_stop_bit_i | input | 1 | Sampled stop bit (0 = framing error) |
| tx_pop_i | input | 1 | Serializer takes the presented byte |
| tx_data_o | output | 8 | Oldest queued transmit byte |
| tx_valid_o | output | 1 | Transmit queue not empty |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | 0 data, 1 control, 2 modem status |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 11 | Read data for the addressed register |
| modem_i | input | 4 | Modem status inputs (synchronous) |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_modem_o | output | 1 | Modem status change interrupt |

## Verification
The receive path is driven with bytes that carry correct parity, wrong parity under both even and odd settings, and a bad stop bit. This separates the two error flags from each other and from the data. Fill patterns stop just below and at the half-full threshold, and go one byte past capacity. These separate the threshold interrupt from overrun reporting, and show that the dropped byte never reappears. Tick bursts of 479 and 480 pin the timeout edge, and a push and pops in between show which events clear it and which only restart it. The same fills are repeated in single-entry mode, and modem toggles are applied with the mask off and on while transmit data waits. These show the interrupt masking and that clear-to-send changes leave the transmit output alone.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int DATA_W  = 8;
  localparam int ENTRY_W = 11;

  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_MSR  = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic              perr;
    logic              ferr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef struct packed {
    logic modem_irq_en;
    logic par_odd;
    logic par_en;
    logic single;
  } ctrl_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             single_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q, cap;
  logic             full, empty, do_push, do_pop;

  assign cap     = single_i ? CNT_W'(1) : CNT_W'(DEPTH);
  assign full    = (count_q == cap);
  assign empty   = (count_q == '0);
  assign do_pop  = pop_i & ~empty;
  // a full queue still accepts a push when the head leaves in the same cycle
  assign do_push = push_i & (~full | do_pop);

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      if (do_pop)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int LIMIT = 480,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic push_i,
  input  logic pop_i,
  input  logic empty_i,
  output logic flag_o
);
  logic [CW-1:0] cnt_q;
  logic          flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (push_i || pop_i || empty_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != CW'(LIMIT)) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // a pop restarts the count but does not withdraw a raised timeout
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (push_i || empty_i) begin
      flag_q <= 1'b0;
    end else if (tick_i && cnt_q == CW'(LIMIT - 1)) begin
      flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uart_modem_delta.sv
module uart_modem_delta #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lines_i,
  input  logic         clr_i,
  output logic         delta_o
);
  logic [W-1:0] prev_q;
  logic         primed_q, delta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      delta_q  <= 1'b0;
    end else begin
      prev_q   <= lines_i;
      primed_q <= 1'b1;
      if (primed_q && lines_i != prev_q) delta_q <= 1'b1;
      else if (clr_i)                    delta_q <= 1'b0;
    end
  end

  assign delta_o = delta_q;
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int MODEM_W       = 4,
  parameter int TICKS_PER_BIT = 16,
  parameter int BITS_PER_CHAR = 10,
  parameter int TIMEOUT_CHARS = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               baud_tick_i,
  input  logic               rx_push_i,
  input  logic [DATA_W-1:0]  rx_data_i,
  input  logic               rx_parity_bit_i,
  input  logic               rx_stop_bit_i,
  input  logic               tx_pop_i,
  output logic [DATA_W-1:0]  tx_data_o,
  output logic               tx_valid_o,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [ENTRY_W-1:0] reg_rdata_o,
  input  logic [MODEM_W-1:0] modem_i,
  output logic               irq_rx_o,
  output logic               irq_tx_o,
  output logic               irq_modem_o
);
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam int HALF     = DEPTH / 2;
  localparam int TO_LIMIT = TIMEOUT_CHARS * BITS_PER_CHAR * TICKS_PER_BIT;
  localparam int RXE_W    = $bits(rx_entry_t);

  ctrl_t            ctrl_q;
  logic             mode_single, modem_irq_en, flush;
  logic             wr_data, rd_data, wr_ctrl, rd_msr;
  rx_entry_t        rx_in, rx_head;
  logic [CNT_W-1:0] rx_count, tx_count, rx_cap;
  logic             rx_empty, rx_full, rx_pop, overrun, ovr_q;
  logic             to_flag, delta;

  assign wr_data = reg_wr_i && reg_addr_i == ADDR_DATA;
  assign wr_ctrl = reg_wr_i && reg_addr_i == ADDR_CTRL;
  assign rd_data = reg_rd_i && reg_addr_i == ADDR_DATA;
  assign rd_msr  = reg_rd_i && reg_addr_i == ADDR_MSR;

  assign mode_single  = ctrl_q.single;
  assign modem_irq_en = ctrl_q.modem_irq_en;
  assign flush        = wr_ctrl && (reg_wdata_i[0] != ctrl_q.single);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i[$bits(ctrl_t)-1:0]);
  end

  // error flags computed at push time
  always_comb begin
    rx_in.data = rx_data_i;
    rx_in.ferr = ~rx_stop_bit_i;
    rx_in.perr = ctrl_q.par_en && (rx_parity_bit_i != ((^rx_data_i) ^ ctrl_q.par_odd));
  end

  assign rx_pop   = rd_data;
  assign rx_cap   = mode_single ? CNT_W'(1) : CNT_W'(DEPTH);
  assign rx_empty = (rx_count == '0);
  assign rx_full  = (rx_count == rx_cap);
  assign overrun  = rx_push_i && rx_full && !rx_pop;

  uart_fifo #(.WIDTH(RXE_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush),
    .single_i (mode_single),
    .push_i   (rx_push_i),
    .data_i   (rx_in),
    .pop_i    (rx_pop),
    .data_o   (rx_head),
    .count_o  (rx_count)
  );

  uart_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush),
    .single_i (mode_single),
    .push_i   (wr_data),
    .data_i   (reg_wdata_i),
    .pop_i    (tx_pop_i),
    .data_o   (tx_data_o),
    .count_o  (tx_count)
  );

  assign tx_valid_o = (tx_count != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovr_q <= 1'b0;
    else if (flush)   ovr_q <= 1'b0;
    else if (overrun) ovr_q <= 1'b1;
    else if (rx_pop)  ovr_q <= 1'b0;
  end

  uart_rx_timeout #(.LIMIT(TO_LIMIT)) u_rx_timeout (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .push_i  (rx_push_i),
    .pop_i   (rx_pop),
    .empty_i (rx_empty),
    .flag_o  (to_flag)
  );

  uart_modem_delta #(.W(MODEM_W)) u_modem_delta (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (modem_i),
    .clr_i   (rd_msr),
    .delta_o (delta)
  );

  assign irq_rx_o    = ovr_q
                     || (rx_count >= (mode_single ? CNT_W'(1) : CNT_W'(HALF)))
                     || (to_flag && !rx_empty);
  assign irq_tx_o    = tx_count <= (mode_single ? CNT_W'(0) : CNT_W'(HALF));
  assign irq_modem_o = delta && modem_irq_en;

  always_comb begin
    case (reg_addr_i)
      ADDR_DATA: reg_rdata_o = {ovr_q, rx_empty ? {RXE_W{1'b0}} : rx_head};
      ADDR_CTRL: reg_rdata_o = ENTRY_W'(ctrl_q);
      ADDR_MSR:  reg_rdata_o = ENTRY_W'({delta, modem_i});
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
  parameter int DEPTH   = 16,
  parameter int MODEM_W = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rx_push_i,
  input logic               rx_full,
  input logic               rx_pop,
  input logic [CNT_W-1:0]   rx_count,
  input logic [CNT_W-1:0]   tx_count,
  input logic               mode_single,
  input logic               modem_irq_en,
  input logic               reg_wr_i,
  input logic [1:0]         reg_addr_i,
  input logic               tx_pop_i,
  input logic [MODEM_W-1:0] modem_i,
  input logic               irq_rx_o,
  input logic               irq_tx_o,
  input logic               irq_modem_o
);
  logic armed_q;
  logic tx_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign tx_full = tx_count == (mode_single ? CNT_W'(1) : CNT_W'(DEPTH));

  // R5
  rx_overrun_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_full && !rx_pop && !(reg_wr_i && reg_addr_i == 2'd1)) |=> irq_rx_o);

  // R3
  rx_empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count == '0) |-> !irq_rx_o);

  // R1
  rx_pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop && rx_count != '0 && !rx_push_i) |=> (rx_count == $past(rx_count) - CNT_W'(1)));

  // R6
  tx_empty_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count == '0) |-> irq_tx_o);

  // R10
  tx_full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd0 && tx_full && !tx_pop_i) |=> (tx_count == $past(tx_count)));

  // R8
  modem_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && modem_i != $past(modem_i) && modem_irq_en && !reg_wr_i) |=> irq_modem_o);
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.DEPTH(DEPTH), .MODEM_W(MODEM_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_push_i    (rx_push_i),
  .rx_full      (rx_full),
  .rx_pop       (rx_pop),
  .rx_count     (rx_count),
  .tx_count     (tx_count),
  .mode_single  (mode_single),
  .modem_irq_en (modem_irq_en),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .tx_pop_i     (tx_pop_i),
  .modem_i      (modem_i),
  .irq_rx_o     (irq_rx_o),
  .irq_tx_o     (irq_tx_o),
  .irq_modem_o  (irq_modem_o)
);

// File: tb/uart_fifo_irq_tb_top.sv
module uart_fifo_irq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        baud_tick_i = 1'b0;
  logic        rx_push_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_parity_bit_i = 1'b0;
  logic        rx_stop_bit_i = 1'b1;
  logic        tx_pop_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [10:0] reg_rdata_o;
  logic [3:0]  modem_i = '0;
  logic        irq_rx_o, irq_tx_o, irq_modem_o;

  always #4 clk_i = ~clk_i;

  uart_fifo_irq dut_i (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [10:0] exp_q[$];
  logic [7:0]  tx_q[$];
  bit exp_ovr = 0;
  bit tb_single = 0, tb_par_en = 0, tb_par_odd = 0, tb_men = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int cap_tb();
    return tb_single ? 1 : 16;
  endfunction

  // driver: pushes a received character and files the expected word
  task automatic rx_push(input logic [7:0] d, input bit par, input bit stop);
    logic perr;
    perr = tb_par_en && (par != ((^d) ^ tb_par_odd));
    if (exp_q.size() < cap_tb()) exp_q.push_back({1'b0, perr, ~stop, d});
    else exp_ovr = 1;
    @(negedge clk_i);
    rx_push_i = 1; rx_data_i = d; rx_parity_bit_i = par; rx_stop_bit_i = stop;
    @(negedge clk_i);
    rx_push_i = 0;
    #1;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 0;
    #1;
  endtask

  task automatic tx_write(input logic [7:0] d);
    if (tx_q.size() < cap_tb()) tx_q.push_back(d);
    reg_write(2'd0, d);
  endtask

  task automatic ctrl_write(input bit single, input bit pen, input bit podd, input bit men);
    if (single != tb_single) begin
      exp_q.delete(); tx_q.delete(); exp_ovr = 0;
    end
    tb_single = single; tb_par_en = pen; tb_par_odd = podd; tb_men = men;
    reg_write(2'd1, {4'b0, men, podd, pen, single});
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [10:0] v);
    @(negedge clk_i);
    reg_rd_i = 1; reg_addr_i = a;
    #2 v = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 0;
    #1;
  endtask

  task automatic rx_read();
    logic [10:0] v;
    reg_read(2'd0, v);
  endtask

  task automatic tx_pop();
    @(negedge clk_i);
    tx_pop_i = 1;
    @(negedge clk_i);
    tx_pop_i = 0;
    #1;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk_i);
      baud_tick_i = 1;
    end
    @(negedge clk_i);
    baud_tick_i = 0;
    #1;
  endtask

  // monitor: compares each data read and each transmit pop against the queues
  always begin
    logic [10:0] e;
    logic [7:0]  t;
    @(negedge clk_i);
    #2;
    if (reg_rd_i && reg_addr_i == 2'd0) begin
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 11'h0;
      e[10] = exp_ovr;
      exp_ovr = 0;
      chk(reg_rdata_o == e, "R1 rx entry", reg_rdata_o, e);
    end
    if (tx_pop_i && tx_valid_o) begin
      t = (tx_q.size() != 0) ? tx_q.pop_front() : 8'h0;
      chk(tx_data_o == t, "R10 tx byte", tx_data_o, t);
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [10:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    // R11
    chk(!irq_rx_o, "R11 irq_rx", irq_rx_o, 0);
    chk(irq_tx_o, "R11 irq_tx", irq_tx_o, 1);
    chk(!irq_modem_o, "R11 irq_modem", irq_modem_o, 0);
    chk(!tx_valid_o, "R11 tx_valid", tx_valid_o, 0);
    reg_read(2'd1, v);
    chk(v == 11'h0, "R11 ctrl", v, 0);

    // R2 even parity, good/bad parity, bad stop
    ctrl_write(0, 1, 0, 0);
    rx_push(8'h55, 0, 1);
    rx_push(8'hA3, 1, 1);
    rx_push(8'h0F, 0, 0);
    rx_read(); rx_read(); rx_read();
    // R2 odd parity
    ctrl_write(0, 1, 1, 0);
    rx_push(8'h01, 0, 1);
    rx_push(8'h03, 0, 1);
    rx_read(); rx_read();
    reg_read(2'd0, v);
    chk(v == 11'h0, "R1 empty read", v, 0);
    ctrl_write(0, 0, 0, 0);

    // R3 half-full threshold
    for (int i = 0; i < 7; i++) rx_push(8'h10 + 8'(i), 0, 1);
    chk(!irq_rx_o, "R3 seven held", irq_rx_o, 0);
    rx_push(8'h17, 0, 1);
    chk(irq_rx_o, "R3 eight held", irq_rx_o, 1);
    rx_read();
    chk(!irq_rx_o, "R3 back to seven", irq_rx_o, 0);
    repeat (7) rx_read();
    chk(!irq_rx_o, "R3 drained", irq_rx_o, 0);

    // R4 timeout
    rx_push(8'h42, 0, 1);
    ticks(479);
    chk(!irq_rx_o, "R4 before limit", irq_rx_o, 0);
    ticks(1);
    chk(irq_rx_o, "R4 at limit", irq_rx_o, 1);
    rx_push(8'h43, 0, 1);
    chk(!irq_rx_o, "R4 push clears", irq_rx_o, 0);
    ticks(480);
    chk(irq_rx_o, "R4 second timeout", irq_rx_o, 1);
    rx_read();
    chk(irq_rx_o, "R4 pop keeps", irq_rx_o, 1);
    rx_read();
    chk(!irq_rx_o, "R4 empty clears", irq_rx_o, 0);

    // R5 overrun in multi-entry mode
    for (int i = 0; i < 16; i++) rx_push(8'h80 + 8'(i), 0, 1);
    rx_push(8'hEE, 0, 1);
    chk(irq_rx_o, "R5 overrun irq", irq_rx_o, 1);
    repeat (16) rx_read();
    chk(!irq_rx_o, "R5 after drain", irq_rx_o, 0);
    chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

    // R6 / R10 transmit queue
    for (int i = 0; i < 8; i++) tx_write(8'hC0 + 8'(i));
    chk(irq_tx_o, "R6 eight queued", irq_tx_o, 1);
    tx_write(8'hC8);
    chk(!irq_tx_o, "R6 nine queued", irq_tx_o, 0);
    for (int i = 9; i < 17; i++) tx_write(8'hC0 + 8'(i));
    // R9 modem change leaves transmit alone; R8 masked
    modem_i = 4'hF;
    @(negedge clk_i); #1;
    chk(tx_valid_o, "R9 tx_valid", tx_valid_o, 1);
    chk(tx_data_o == 8'hC0, "R9 tx_data", tx_data_o, 8'hC0);
    chk(!irq_modem_o, "R8 masked", irq_modem_o, 0);
    modem_i = 4'h0;
    repeat (7) tx_pop();
    chk(!irq_tx_o, "R6 nine left", irq_tx_o, 0);
    tx_pop();
    chk(irq_tx_o, "R6 eight left", irq_tx_o, 1);
    repeat (8) tx_pop();
    chk(!tx_valid_o, "R10 drained, extra byte dropped", tx_valid_o, 0);
    chk(tx_q.size() == 0, "R10 scoreboard empty", tx_q.size(), 0);

    // R8 status read and mask
    reg_read(2'd2, v);
    chk(v == 11'h010, "R8 latched flag", v, 11'h010);
    reg_read(2'd2, v);
    chk(v == 11'h000, "R8 flag cleared", v, 0);
    ctrl_write(0, 0, 0, 1);
    @(negedge clk_i);
    modem_i = 4'h2;
    @(negedge clk_i); #1;
    chk(irq_modem_o, "R8 unmasked irq", irq_modem_o, 1);
    reg_read(2'd2, v);
    chk(v == 11'h012, "R8 status value", v, 11'h012);
    chk(!irq_modem_o, "R8 irq after read", irq_modem_o, 0);

    // R7 single-entry mode and flush
    rx_push(8'h5A, 0, 1);
    tx_write(8'h6B);
    ctrl_write(1, 0, 0, 1);
    chk(!irq_rx_o, "R7 rx flushed", irq_rx_o, 0);
    chk(!tx_valid_o, "R7 tx flushed", tx_valid_o, 0);
    chk(irq_tx_o, "R7 tx irq empty", irq_tx_o, 1);
    rx_push(8'h11, 0, 1);
    chk(irq_rx_o, "R7 one entry irq", irq_rx_o, 1);
    rx_push(8'h22, 0, 1);
    rx_read();
    chk(!irq_rx_o, "R7 rx after read", irq_rx_o, 0);
    tx_write(8'h33);
    chk(!irq_tx_o, "R7 tx one held", irq_tx_o, 0);
    tx_write(8'h44);
    tx_pop();
    chk(!tx_valid_o, "R7 tx second dropped", tx_valid_o, 0);

    repeat (4) @(negedge clk_i);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule